// File: doc/BRIEF.md
# Byte-Wide Pipelined Converter Read Sequencer

This block is a host-side master that services a 12-bit successive-approximation converter through a narrow read port, without stalling the requester. Each sample request is served by a short series of read strobes on the converter's chip-select, read and high-byte-enable lines. The read that fetches a result also launches the next conversion, so a conversion is always in flight after the first sample. When the sequencer has no conversion in flight, as after reset, it first issues a priming read. That read starts a conversion, and the stale word it returns is dropped.

Two read styles are supported and chosen per sample by a configuration input. In byte style the sequencer fetches the upper nibble with high-byte-enable raised. It then fetches the low byte with the enable lowered, and that read also starts the next conversion. In parallel style one read returns all twelve bits and starts the next conversion. All spacing rules are counted in system clock cycles: strobe width, strobe-to-strobe gap, conversion time and reacquisition time. The assembled result leaves on a valid/ready output, zero-extended into a wider word.

Top module: `adc_rom_reader`

## Requirements
- R1: While reset is high, and after it until the first request, chip select and read stay high (inactive) and word_valid stays low.
- R2: The first read after reset has high-byte-enable low and starts a conversion. Its returned data never reaches word_data, so the first delivered word is the result of the conversion that read started.
- R3: In byte style (wide_mode=0), a primed sample uses two reads. The first has high-byte-enable high and takes the result's bits 11:8 from bus bits 3:0. The second has high-byte-enable low, takes bits 7:0 from bus bits 7:0, and starts the next conversion.
- R4: In parallel style (wide_mode=1), a primed sample uses exactly one read. It has high-byte-enable low, takes all twelve bits from bus bits 11:0, and starts the next conversion.
- R5: A read with high-byte-enable high falls no fewer than CONV_CYC cycles after the falling edge of the most recent conversion-starting read.
- R6: Two conversion-starting reads (high-byte-enable low) fall no fewer than CONV_CYC+ACQ_CYC cycles apart.
- R7: Read stays low for exactly RD_LOW cycles per strobe and stays high for at least RD_GAP cycles between strobes.
- R8: Chip select is low in the cycle before read falls, in every cycle that read is low, and in the cycle read rises. High-byte-enable does not change from the cycle before read falls through the cycle read rises.
- R9: word_data carries the 12-bit result in bits 11:0 with the bits above zero. Once word_valid is high it stays high, with word_data unchanged, until a cycle with word_ready high.
- R10: A request that arrives while a sample is in progress is held and served afterwards. Any number of requests during one sample collapse into a single extra sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_req | input | 1 | One-cycle pulse asking for one converted sample |
| wide_mode | input | 1 | 1 selects one 12-bit read per sample, 0 selects byte reads; taken when a sample begins |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_rd_n | output | 1 | Converter read strobe, active low |
| adc_hbe | output | 1 | Converter high-byte-enable |
| adc_bus | input | RES_W | Converter data bus; byte style uses bits 7:0 |
| word_data | output | OUT_W | Result word, right-justified |
| word_valid | output | 1 | Result word available |
| word_ready | input | 1 | Consumer accepts the word in this cycle |

## Verification
A request pulse is registered in the next cycle, and chip select drops one cycle later. From then on, every read's falling edge is gated by the pacing counters, so its exact cycle depends on the previous strobes. The bench therefore does not predict word arrival times. It measures each spacing rule directly, counting falling-edge clock cycles between observed read edges against the bounds of R5, R6 and R7. The result word appears one cycle after the last low cycle of the fetching read. The scoreboard compares it, in order, with the value the bench's converter model produced for that conversion index, and also compares the number of reads seen since the previous accepted word. Outputs are sampled at the falling clock edge, half a cycle after the registers update.

// File: rtl/adc_rom_reader_pkg.sv
package adc_rom_reader_pkg;

   // phase of a single read strobe
   typedef enum logic [1:0] {
      PH_IDLE,
      PH_SETUP,
      PH_STROBE,
      PH_HOLD
   } phase_t;

   // purpose of the read being issued
   typedef enum logic [1:0] {
      RK_FLUSH,   // starts a conversion, data dropped
      RK_UPPER,   // high-byte-enable high, fetch top bits
      RK_LOWER,   // fetch low byte, starts next conversion
      RK_WHOLE    // fetch full word, starts next conversion
   } rkind_t;

endpackage

// File: rtl/adc_rom_reader_pacer.sv
module adc_rom_reader_pacer #(
   parameter int RD_GAP   = 10,
   parameter int CONV_CYC = 150,
   parameter int ACQ_CYC  = 50
) (
   input  logic clk,
   input  logic rst,
   input  logic rd_low,
   input  logic launch,
   output logic gap_ok,
   output logic fetch_ok,
   output logic restart_ok
);
   localparam int SPAN   = CONV_CYC + ACQ_CYC;
   localparam int GAP_W  = $clog2(RD_GAP + 1);
   localparam int SPAN_W = $clog2(SPAN + 1);

   logic [GAP_W-1:0]  gap_q;
   logic [SPAN_W-1:0] span_q;

   // cycles with read high since the last strobe
   always_ff @(posedge clk) begin
      if (rst)
         gap_q <= GAP_W'(RD_GAP);
      else if (rd_low)
         gap_q <= '0;
      else if (gap_q != GAP_W'(RD_GAP))
         gap_q <= gap_q + GAP_W'(1);
   end

   // cycles since the last conversion-starting strobe fell
   always_ff @(posedge clk) begin
      if (rst)
         span_q <= SPAN_W'(SPAN);
      else if (launch)
         span_q <= '0;
      else if (span_q != SPAN_W'(SPAN))
         span_q <= span_q + SPAN_W'(1);
   end

   // a strobe leaving setup now falls one cycle after the count
   assign gap_ok     = gap_q  >= GAP_W'(RD_GAP - 1);
   assign fetch_ok   = span_q >= SPAN_W'(CONV_CYC - 1);
   assign restart_ok = span_q >= SPAN_W'(SPAN - 1);

endmodule

// File: rtl/adc_rom_reader_strobe.sv
module adc_rom_reader_strobe
   import adc_rom_reader_pkg::*;
#(
   parameter int RD_LOW = 5
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic permit,
   input  logic cont,
   input  logic upper,
   output logic cs_n,
   output logic rd_n,
   output logic hbe,
   output logic seq_idle,
   output logic hold_now,
   output logic capture,
   output logic launch
);
   localparam int CNT_W = (RD_LOW > 1) ? $clog2(RD_LOW) : 1;

   phase_t phase_q;
   logic   last;

   generate
      if (RD_LOW > 1) begin : g_count
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (rst || phase_q != PH_STROBE)
               cnt_q <= '0;
            else
               cnt_q <= cnt_q + CNT_W'(1);
         end
         assign last = (cnt_q == CNT_W'(RD_LOW - 1));
      end else begin : g_single
         assign last = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_IDLE;
      end else begin
         case (phase_q)
            PH_IDLE:   if (start)  phase_q <= PH_SETUP;
            PH_SETUP:  if (permit) phase_q <= PH_STROBE;
            PH_STROBE: if (last)   phase_q <= PH_HOLD;
            PH_HOLD:   phase_q <= cont ? PH_SETUP : PH_IDLE;
            default:   phase_q <= PH_IDLE;
         endcase
      end
   end

   assign cs_n     = (phase_q == PH_IDLE);
   assign rd_n     = (phase_q != PH_STROBE);
   assign hbe      = (phase_q != PH_IDLE) && upper;
   assign seq_idle = (phase_q == PH_IDLE);
   assign hold_now = (phase_q == PH_HOLD);
   assign capture  = (phase_q == PH_STROBE) && last;
   assign launch   = (phase_q == PH_SETUP) && permit && !upper;

endmodule

// File: rtl/adc_rom_reader_pack.sv
module adc_rom_reader_pack
   import adc_rom_reader_pkg::*;
#(
   parameter int RES_W  = 12,
   parameter int BYTE_W = 8,
   parameter int OUT_W  = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             capture,
   input  rkind_t           kind,
   input  logic [RES_W-1:0] bus,
   output logic [OUT_W-1:0] word_data,
   output logic             word_valid,
   input  logic             word_ready
);
   localparam int HI_W = RES_W - BYTE_W;

   logic [HI_W-1:0]  hi_q;
   logic [RES_W-1:0] res_q;
   logic             vld_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         hi_q  <= '0;
         res_q <= '0;
         vld_q <= 1'b0;
      end else begin
         if (vld_q && word_ready)
            vld_q <= 1'b0;
         if (capture) begin
            case (kind)
               RK_UPPER: hi_q <= bus[HI_W-1:0];
               RK_LOWER: begin
                  res_q <= {hi_q, bus[BYTE_W-1:0]};
                  vld_q <= 1'b1;
               end
               RK_WHOLE: begin
                  res_q <= bus;
                  vld_q <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   generate
      if (OUT_W > RES_W) begin : g_pad
         assign word_data = {{(OUT_W - RES_W){1'b0}}, res_q};
      end else begin : g_exact
         assign word_data = res_q;
      end
   endgenerate

   assign word_valid = vld_q;

endmodule

// File: rtl/adc_rom_reader.sv
module adc_rom_reader
   import adc_rom_reader_pkg::*;
#(
   parameter int RES_W    = 12,
   parameter int BYTE_W   = 8,
   parameter int OUT_W    = 16,
   parameter int RD_LOW   = 5,
   parameter int RD_GAP   = 10,
   parameter int CONV_CYC = 150,
   parameter int ACQ_CYC  = 50
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sample_req,
   input  logic             wide_mode,
   output logic             adc_cs_n,
   output logic             adc_rd_n,
   output logic             adc_hbe,
   input  logic [RES_W-1:0] adc_bus,
   output logic [OUT_W-1:0] word_data,
   output logic             word_valid,
   input  logic             word_ready
);
   generate
      if (RES_W <= BYTE_W || RES_W > 2 * BYTE_W) begin : g_bad_res
         $error("RES_W must need exactly two byte reads");
      end
      if (OUT_W < RES_W) begin : g_bad_out
         $error("OUT_W narrower than RES_W");
      end
      if (RD_LOW < 1 || RD_GAP < 2 || CONV_CYC < 1 || ACQ_CYC < 0) begin : g_bad_time
         $error("timing parameters out of range");
      end
   endgenerate

   rkind_t kind_q;
   logic   req_q, primed_q, wide_q;
   logic   gap_ok, fetch_ok, restart_ok;
   logic   upper, permit, start, cont;
   logic   seq_idle, hold_now, capture, launch;

   assign upper  = (kind_q == RK_UPPER);
   assign permit = gap_ok && (upper ? fetch_ok : restart_ok);
   assign start  = seq_idle && req_q && !word_valid;
   assign cont   = (kind_q == RK_FLUSH) || upper;

   always_ff @(posedge clk) begin
      if (rst) begin
         req_q    <= 1'b0;
         primed_q <= 1'b0;
         wide_q   <= 1'b0;
         kind_q   <= RK_FLUSH;
      end else begin
         req_q <= (req_q && !start) || sample_req;
         if (launch)
            primed_q <= 1'b1;
         if (start) begin
            wide_q <= wide_mode;
            if (!primed_q)
               kind_q <= RK_FLUSH;
            else
               kind_q <= wide_mode ? RK_WHOLE : RK_UPPER;
         end else if (hold_now) begin
            case (kind_q)
               RK_FLUSH: kind_q <= wide_q ? RK_WHOLE : RK_UPPER;
               RK_UPPER: kind_q <= RK_LOWER;
               default:  ;
            endcase
         end
      end
   end

   adc_rom_reader_pacer #(
      .RD_GAP(RD_GAP), .CONV_CYC(CONV_CYC), .ACQ_CYC(ACQ_CYC)
   ) u_pacer (
      .clk(clk), .rst(rst), .rd_low(!adc_rd_n), .launch(launch),
      .gap_ok(gap_ok), .fetch_ok(fetch_ok), .restart_ok(restart_ok)
   );

   adc_rom_reader_strobe #(
      .RD_LOW(RD_LOW)
   ) u_strobe (
      .clk(clk), .rst(rst), .start(start), .permit(permit), .cont(cont),
      .upper(upper), .cs_n(adc_cs_n), .rd_n(adc_rd_n), .hbe(adc_hbe),
      .seq_idle(seq_idle), .hold_now(hold_now), .capture(capture),
      .launch(launch)
   );

   adc_rom_reader_pack #(
      .RES_W(RES_W), .BYTE_W(BYTE_W), .OUT_W(OUT_W)
   ) u_pack (
      .clk(clk), .rst(rst), .capture(capture), .kind(kind_q),
      .bus(adc_bus), .word_data(word_data), .word_valid(word_valid),
      .word_ready(word_ready)
   );

endmodule

// File: rtl/adc_rom_reader_chk.sv
module adc_rom_reader_chk #(
   parameter int RES_W    = 12,
   parameter int OUT_W    = 16,
   parameter int RD_LOW   = 5,
   parameter int RD_GAP   = 10,
   parameter int CONV_CYC = 150,
   parameter int ACQ_CYC  = 50
) (
   input logic             clk,
   input logic             rst,
   input logic             cs_n,
   input logic             rd_n,
   input logic             hbe,
   input logic [OUT_W-1:0] word_data,
   input logic             word_valid,
   input logic             word_ready
);
   localparam int SPAN   = CONV_CYC + ACQ_CYC;
   localparam int SPAN_W = $clog2(SPAN + 1);
   localparam int GAP_W  = $clog2(RD_GAP + 1);
   localparam int LOW_W  = $clog2(RD_LOW + 2);

   logic              rd_q;
   logic [GAP_W-1:0]  hi_cnt;
   logic [LOW_W-1:0]  lo_cnt;
   logic [SPAN_W-1:0] span_cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_q     <= 1'b1;
         hi_cnt   <= GAP_W'(RD_GAP);
         lo_cnt   <= '0;
         span_cnt <= SPAN_W'(SPAN);
      end else begin
         rd_q <= rd_n;
         if (!rd_n)
            hi_cnt <= '0;
         else if (hi_cnt != GAP_W'(RD_GAP))
            hi_cnt <= hi_cnt + GAP_W'(1);
         if (!rd_n)
            lo_cnt <= rd_q ? LOW_W'(1) :
                      (lo_cnt == LOW_W'(RD_LOW + 1) ? lo_cnt : lo_cnt + LOW_W'(1));
         if (rd_q && !rd_n && !hbe)
            span_cnt <= SPAN_W'(1);
         else if (span_cnt != SPAN_W'(SPAN))
            span_cnt <= span_cnt + SPAN_W'(1);
      end
   end

   // R7
   strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_q && !rd_n) |-> hi_cnt >= GAP_W'(RD_GAP));
   // R7
   strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
      (!rd_q && rd_n) |-> lo_cnt == LOW_W'(RD_LOW));
   // R5
   fetch_wait_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_q && !rd_n && hbe) |-> span_cnt >= SPAN_W'(CONV_CYC));
   // R6
   restart_wait_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_q && !rd_n && !hbe) |-> span_cnt >= SPAN_W'(SPAN));
   // R8
   select_cover_chk: assert property (@(posedge clk) disable iff (rst)
      (!rd_n || !rd_q) |-> !cs_n);
   // R8
   select_lead_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_q && !rd_n) |-> $past(!cs_n));
   // R8
   hbe_steady_chk: assert property (@(posedge clk) disable iff (rst)
      (!rd_n || !rd_q) |-> $stable(hbe));
   // R9
   word_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (word_valid && !word_ready) |=> (word_valid && $stable(word_data)));

   generate
      if (OUT_W > RES_W) begin : g_pad_chk
         // R9
         word_pad_chk: assert property (@(posedge clk) disable iff (rst)
            word_valid |-> (word_data[OUT_W-1:RES_W] == '0));
      end
   endgenerate

endmodule

bind adc_rom_reader adc_rom_reader_chk #(
   .RES_W(RES_W), .OUT_W(OUT_W), .RD_LOW(RD_LOW), .RD_GAP(RD_GAP),
   .CONV_CYC(CONV_CYC), .ACQ_CYC(ACQ_CYC)
) u_chk (
   .clk(clk), .rst(rst), .cs_n(adc_cs_n), .rd_n(adc_rd_n), .hbe(adc_hbe),
   .word_data(word_data), .word_valid(word_valid), .word_ready(word_ready)
);

// File: tb/adc_rom_reader_test.sv
`timescale 1ns/1ps
module adc_rom_reader_test;
   localparam int RD_LOW = 5, RD_GAP = 10, CONV = 150, ACQ = 50;

   logic        clk = 1'b0, rst = 1'b1, sample_req = 1'b0, wide = 1'b0;
   logic        word_ready = 1'b1;
   logic        adc_cs_n, adc_rd_n, adc_hbe, word_valid;
   logic [11:0] adc_bus, m_res = 12'h000;
   logic [15:0] word_data;

   always #10 clk = ~clk;

   assign adc_bus = adc_hbe ? {m_res[11:8], 4'b0000, m_res[11:8]} : m_res;

   adc_rom_reader #(
      .RES_W(12), .BYTE_W(8), .OUT_W(16), .RD_LOW(RD_LOW), .RD_GAP(RD_GAP),
      .CONV_CYC(CONV), .ACQ_CYC(ACQ)
   ) uut (
      .clk(clk), .rst(rst), .sample_req(sample_req), .wide_mode(wide),
      .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n), .adc_hbe(adc_hbe),
      .adc_bus(adc_bus), .word_data(word_data), .word_valid(word_valid),
      .word_ready(word_ready)
   );

   int n_checks = 0, n_err = 0;
   int q_val[$], q_reads[$];
   bit q_wide[$];
   bit primed_b = 0, ready_mode = 0;
   int sample_idx = 0;

   function automatic int conv_val(int k);
      return (k * 2471 + 309) & 4095;
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   endtask

   // driver: one request pulse, expectation pushed to scoreboard
   task automatic request();
      @(negedge clk);
      sample_req = 1'b1;
      q_val.push_back(conv_val(sample_idx));
      q_reads.push_back((wide ? 1 : 2) + (primed_b ? 0 : 1));
      q_wide.push_back(wide);
      sample_idx++;
      primed_b = 1;
      @(negedge clk);
      sample_req = 1'b0;
   endtask

   task automatic pulse_only();
      @(negedge clk);
      sample_req = 1'b1;
      @(negedge clk);
      sample_req = 1'b0;
   endtask

   task automatic drain();
      while (q_val.size() != 0) @(negedge clk);
      repeat (30) @(negedge clk);
   endtask

   // ready pattern
   initial begin
      int k = 0;
      forever begin
         @(negedge clk);
         k++;
         word_ready = ready_mode ? ((k % 5) == 4) : 1'b1;
      end
   end

   // converter model, timing monitor and scoreboard
   int cyc = 0, hi_len, lo_len, last_start, done_cyc, reads_since, conv_idx = 0;
   int pend;
   bit prev_rd, prev_cs, conv_on, have_start, first_fall = 1, fall_hbe;
   bit prev_v, prev_r;
   logic [15:0] prev_d;

   always @(negedge clk) begin
      cyc++;
      if (rst) begin
         prev_rd = 1; prev_cs = 1; hi_len = 1000; lo_len = 0;
         conv_on = 0; have_start = 0; reads_since = 0; prev_v = 0; prev_r = 0;
      end else begin
         if (conv_on && cyc >= done_cyc) begin
            m_res = 12'(pend);
            conv_on = 0;
         end
         if (!adc_rd_n) begin
            if (prev_rd) begin
               reads_since++;
               check(hi_len >= RD_GAP, "R7 gap", hi_len, RD_GAP);
               check(!prev_cs && !adc_cs_n, "R8 select lead", prev_cs, 0);
               fall_hbe = adc_hbe;
               if (first_fall) begin
                  check(!adc_hbe, "R2 first read hbe", adc_hbe, 0);
                  first_fall = 0;
               end
               if (adc_hbe) begin
                  check(have_start && (cyc - last_start >= CONV), "R5 fetch wait",
                        cyc - last_start, CONV);
               end else begin
                  if (have_start)
                     check(cyc - last_start >= CONV + ACQ, "R6 restart wait",
                           cyc - last_start, CONV + ACQ);
                  pend = conv_val(conv_idx);
                  conv_idx++;
                  conv_on = 1;
                  done_cyc = cyc + CONV;
                  last_start = cyc;
                  have_start = 1;
               end
               lo_len = 1;
            end else begin
               lo_len++;
            end
         end else begin
            if (!prev_rd) begin
               check(lo_len == RD_LOW, "R7 width", lo_len, RD_LOW);
               check(!adc_cs_n, "R8 select hold", adc_cs_n, 0);
               check(adc_hbe == fall_hbe, "R8 hbe steady", adc_hbe, fall_hbe);
               hi_len = 1;
            end else begin
               hi_len++;
            end
         end

         if (prev_v && !prev_r)
            check(word_valid && word_data == prev_d, "R9 hold", word_data, prev_d);

         if (word_valid && word_ready) begin
            if (q_val.size() == 0) begin
               check(0, "R10 unexpected word", word_data, 0);
            end else begin
               int ev, er;
               bit ew;
               ev = q_val.pop_front();
               er = q_reads.pop_front();
               ew = q_wide.pop_front();
               check(word_data == 16'(ev), ew ? "R4 value" : "R3 value", word_data, ev);
               check(reads_since == er, ew ? "R4 read count" : "R3 read count",
                     reads_since, er);
               check(word_data[15:12] == 4'h0, "R9 pad", word_data[15:12], 0);
            end
            reads_since = 0;
         end

         prev_v = word_valid;
         prev_r = word_ready;
         prev_d = word_data;
         prev_rd = adc_rd_n;
         prev_cs = adc_cs_n;
      end
   end

   initial begin
      repeat (150000) @(negedge clk);
      check(0, "watchdog", cyc, 0);
      finish_run();
   end

   initial begin
      repeat (5) @(negedge clk);
      check(adc_cs_n && adc_rd_n && !word_valid, "R1 in reset",
            {adc_cs_n, adc_rd_n, word_valid}, 3'b110);
      rst = 1'b0;
      repeat (20) @(negedge clk);
      check(adc_cs_n && adc_rd_n && !word_valid, "R1 after reset",
            {adc_cs_n, adc_rd_n, word_valid}, 3'b110);

      // byte style, free-flowing consumer
      for (int i = 0; i < 4; i++) begin request(); drain(); end
      // byte style under backpressure
      ready_mode = 1;
      for (int i = 0; i < 3; i++) begin request(); drain(); end
      ready_mode = 0;
      // parallel style
      wide = 1'b1;
      for (int i = 0; i < 4; i++) begin request(); drain(); end
      // R10: extra pulses during a sample collapse into one
      request();
      repeat (30) @(negedge clk);
      request();
      repeat (3) @(negedge clk);
      pulse_only();
      repeat (3) @(negedge clk);
      pulse_only();
      drain();
      // back to byte style with a request latched mid-sample
      wide = 1'b0;
      request();
      repeat (2) @(negedge clk);
      request();
      drain();
      repeat (400) @(negedge clk);
      check(q_val.size() == 0, "R10 queue empty", q_val.size(), 0);
      finish_run();
   end
endmodule